// File: doc/BRIEF.md
# Host Mailbox FIFO Register Interface

This block gives a host processor a small register window for talking to a peripheral microcontroller over two byte queues. The host sends bytes by writing a data word: each write queues one byte in an outbound FIFO. The microcontroller takes bytes from that FIFO through a valid/ready port. In the other direction, the microcontroller offers bytes on a second port. They collect in an inbound FIFO, and the host removes them one per read of the data word.

Three word registers sit at fixed word offsets: interrupt control at 0, data at 1 and status at 2. Offsets 3 to 7 are reserved. The byte always travels in bits 15:8 of the data word.

The block watches four conditions:
- bit 0: outbound queue empty;
- bit 1: outbound queue has room;
- bit 2: inbound queue holds data;
- bit 3: inbound byte lost.

The status register shows these conditions. In the interrupt register, each condition has a latched request bit and its own enable bit. The single interrupt line is raised when any enabled request is pending.

The inbound port signals ready only while the inbound FIFO has room. A byte offered while that port is not ready is discarded and counts as lost.

Top module: `mbox_host_if`

## Requirements
- R1: After reset the status register reads 0x3 (outbound empty, outbound has room), the interrupt register reads 0x0, `irq_o` is low and `tx_byte_valid` is low.
- R2: A register write to word offset 1 queues `reg_wdata[15:8]` in the outbound FIFO; the other write bits are ignored. Queued bytes leave on `tx_byte_data` in write order, one per cycle in which `tx_byte_valid` and `tx_byte_ready` are both high.
- R3: The outbound FIFO holds DEPTH (8) bytes. When it is full, status bit 1 reads 0, and a further data write is discarded without changing the queued contents. Status bit 0 reads 1 only while the outbound FIFO is empty.
- R4: A register read of word offset 1 removes the oldest inbound byte and returns it as {16'h0, byte, 8'h0} on `reg_rdata`, in the cycle after the read strobe. Inbound bytes come back in arrival order.
- R5: A data read while the inbound FIFO is empty returns 0x00000000 and leaves the FIFO unchanged, so a byte arriving afterwards is the next byte read.
- R6: When `rx_byte_valid` is high while the inbound FIFO holds DEPTH bytes, the byte is dropped, and both status bit 3 and interrupt request bit 3 are set. Each of these stays set until a 1 is written to that same bit position in its own register.
- R7: Interrupt request bits 0 to 2 are set on a 0-to-1 transition of status bits 0 to 2 respectively. Writing 1 to a request bit at offset 0 clears it, and writing 0 leaves it unchanged.
- R8: Interrupt register bits 7:4 are enables for request bits 3:0, read back as written. `irq_o` is high exactly when some request bit and its enable are both 1, and it follows the register state with no extra cycle.
- R9: Reads of word offsets 3 to 7 return zero, and writes to them change no register or FIFO.
- R10: Status bits 0 to 2 always show the live FIFO state; writing to them has no effect. Status bits 31:4 and interrupt register bits 31:8 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_addr | input | 3 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after `reg_rd` |
| irq_o | output | 1 | Interrupt to host, registered |
| tx_byte_valid | output | 1 | Outbound byte available |
| tx_byte_data | output | 8 | Outbound byte |
| tx_byte_ready | input | 1 | Microcontroller accepts the outbound byte |
| rx_byte_valid | input | 1 | Microcontroller offers an inbound byte |
| rx_byte_data | input | 8 | Inbound byte |
| rx_byte_ready | output | 1 | Inbound FIFO has room |

## Verification
A read or write pointer that has gone out of step shows up on the very next status read as a wrong empty or full bit. It also shows up at the next data read or outbound handshake as a byte out of order or a byte repeated. A stale edge-detect register shows up as a request bit that is set spuriously or not at all. Because the line is registered from the next-state values, that error reaches `irq_o` in the same cycle. A lost overflow flag is visible at the first status read after the dropped byte. A random mix of host and microcontroller operations, each compared with a byte-queue model after every step, surfaces these faults within a few operations of their cause.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W    = 3;
  localparam int REG_W     = 32;
  localparam int BYTE_W    = 8;
  localparam int BYTE_LSB  = 8;   // byte lane in data word
  localparam int NCOND     = 4;

  localparam logic [ADDR_W-1:0] OFS_INTR = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd2;

  // condition bit positions, shared by status and request fields
  localparam int C_TX_EMPTY = 0;
  localparam int C_TX_ROOM  = 1;
  localparam int C_RX_AVAIL = 2;
  localparam int C_RX_LOST  = 3;
endpackage

// File: rtl/mbox_byte_fifo.sv
module mbox_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: occupancy never passes the depth
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R5: popping an empty queue leaves the read side untouched
  assert_empty_pop_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> ($stable(rd_ptr) && empty));
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl #(
  parameter int NLVL = 3,
  parameter logic [NLVL-1:0] LVL_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLVL-1:0]   lvl_i,
  input  logic              evt_i,
  input  logic              wr_en,
  input  logic [2*(NLVL+1)-1:0] wr_data,
  output logic [NLVL:0]     req_o,
  output logic [NLVL:0]     en_o,
  output logic              irq_o
);
  localparam int NC = NLVL + 1;

  logic [NLVL-1:0] lvl_prev;
  logic [NC-1:0]   req_q, en_q, req_d, en_d, set_v, clr_v;
  logic            irq_q;

  for (genvar i = 0; i < NLVL; i++) begin : g_edge
    assign set_v[i] = lvl_i[i] && !lvl_prev[i];
  end
  assign set_v[NC-1] = evt_i;

  assign clr_v = wr_en ? wr_data[NC-1:0] : '0;
  assign req_d = (req_q & ~clr_v) | set_v;   // set wins
  assign en_d  = wr_en ? wr_data[2*NC-1:NC] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev <= LVL_RST;
      req_q    <= '0;
      en_q     <= '0;
      irq_q    <= 1'b0;
    end else begin
      lvl_prev <= lvl_i;
      req_q    <= req_d;
      en_q     <= en_d;
      irq_q    <= |(req_d & en_d);
    end
  end

  assign req_o = req_q;
  assign en_o  = en_q;
  assign irq_o = irq_q;

  // R7: a rising condition always leaves its request set
  for (genvar j = 0; j < NLVL; j++) begin : g_chk
    assert_edge_sets_req_R7: assert property (@(posedge clk) disable iff (rst)
      (lvl_i[j] && !lvl_prev[j]) |=> req_q[j]);
  end

  // R8: with every enable clear the line stays low
  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> !irq_q);
endmodule

// File: rtl/mbox_host_if.sv
module mbox_host_if
  import mbox_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_o,
  output logic        tx_byte_valid,
  output logic [7:0]  tx_byte_data,
  input  logic        tx_byte_ready,
  input  logic        rx_byte_valid,
  input  logic [7:0]  rx_byte_data,
  output logic        rx_byte_ready
);
  localparam int NLVL = NCOND - 1;

  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [BYTE_W-1:0] tx_head, rx_head;
  logic              wr_data_hit, rd_data_hit, wr_intr_hit, wr_stat_hit;
  logic              rx_drop, ovf_q;
  logic [NLVL-1:0]   lvl;
  logic [NCOND-1:0]  req, en, stat_v;
  logic [REG_W-1:0]  rd_mux, rdata_q;

  assign wr_data_hit = reg_wr && (reg_addr == OFS_DATA);
  assign rd_data_hit = reg_rd && (reg_addr == OFS_DATA);
  assign wr_intr_hit = reg_wr && (reg_addr == OFS_INTR);
  assign wr_stat_hit = reg_wr && (reg_addr == OFS_STAT);

  mbox_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_tx_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_data_hit),
    .push_data (reg_wdata[BYTE_LSB +: BYTE_W]),
    .pop       (tx_byte_ready),
    .head      (tx_head),
    .empty     (tx_empty),
    .full      (tx_full)
  );

  mbox_byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rx_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (rx_byte_valid),
    .push_data (rx_byte_data),
    .pop       (rd_data_hit),
    .head      (rx_head),
    .empty     (rx_empty),
    .full      (rx_full)
  );

  assign tx_byte_valid = !tx_empty;
  assign tx_byte_data  = tx_head;
  assign rx_byte_ready = !rx_full;
  assign rx_drop       = rx_byte_valid && rx_full;

  // sticky lost-byte status, write-one-to-clear, set wins
  always_ff @(posedge clk) begin
    if (rst) ovf_q <= 1'b0;
    else if (rx_drop) ovf_q <= 1'b1;
    else if (wr_stat_hit && reg_wdata[C_RX_LOST]) ovf_q <= 1'b0;
  end

  assign lvl[C_TX_EMPTY] = tx_empty;
  assign lvl[C_TX_ROOM]  = !tx_full;
  assign lvl[C_RX_AVAIL] = !rx_empty;
  assign stat_v = {ovf_q, lvl};

  mbox_irq_ctrl #(.NLVL(NLVL), .LVL_RST(3'b011)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .lvl_i   (lvl),
    .evt_i   (rx_drop),
    .wr_en   (wr_intr_hit),
    .wr_data (reg_wdata[2*NCOND-1:0]),
    .req_o   (req),
    .en_o    (en),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_INTR: rd_mux[2*NCOND-1:0] = {en, req};
      OFS_DATA: if (!rx_empty) rd_mux[BYTE_LSB +: BYTE_W] = rx_head;
      OFS_STAT: rd_mux[NCOND-1:0] = stat_v;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

  // R6: a dropped inbound byte always leaves the lost flag set
  assert_drop_flags_R6: assert property (@(posedge clk) disable iff (rst)
    rx_drop |=> (ovf_q && req[C_RX_LOST]));

  // R9: reserved offsets read as zero
  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr > OFS_STAT) |=> (reg_rdata == '0));

  // R2: an accepted data write makes a byte available
  assert_write_visible_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_data_hit && !tx_full && !tx_byte_ready) |=> tx_byte_valid);
endmodule

// File: tb/mbox_host_if_tb.sv
module mbox_host_if_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, tx_byte_valid, tx_byte_ready = 1'b0;
  logic [7:0]  tx_byte_data;
  logic        rx_byte_valid = 1'b0, rx_byte_ready;
  logic [7:0]  rx_byte_data = '0;

  int checks = 0, errors = 0;
  logic [7:0] tx_m[$];
  logic [7:0] rx_m[$];
  bit ovf_m = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  mbox_host_if u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .tx_byte_valid(tx_byte_valid), .tx_byte_data(tx_byte_data),
    .tx_byte_ready(tx_byte_ready), .rx_byte_valid(rx_byte_valid),
    .rx_byte_data(rx_byte_data), .rx_byte_ready(rx_byte_ready)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return {28'h0, ovf_m, rx_m.size() != 0, tx_m.size() != 8, tx_m.size() == 0};
  endfunction

  function automatic logic [31:0] data_word(logic [7:0] b);
    return {16'h0, b, 8'h0};
  endfunction

  task automatic reg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
    if (a == 3'd1 && tx_m.size() < 8) tx_m.push_back(d[15:8]);
    if (a == 3'd2 && d[3]) ovf_m = 0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic rx_push(logic [7:0] b);
    @(negedge clk); rx_byte_valid = 1'b1; rx_byte_data = b;
    @(negedge clk); rx_byte_valid = 1'b0;
    if (rx_m.size() < 8) rx_m.push_back(b); else ovf_m = 1;
  endtask

  task automatic tx_drain_one(string rq);
    @(negedge clk);
    if (tx_m.size() == 0) begin
      chk(rq, {31'h0, tx_byte_valid}, 32'h0);
    end else begin
      logic [7:0] e;
      e = tx_m.pop_front();
      chk(rq, {31'h0, tx_byte_valid}, 32'h1);
      chk(rq, {24'h0, tx_byte_data}, {24'h0, e});
      tx_byte_ready = 1'b1;
      @(negedge clk); tx_byte_ready = 1'b0;
    end
  endtask

  task automatic read_data_chk(string rq);
    logic [31:0] d, e;
    e = (rx_m.size() != 0) ? data_word(rx_m.pop_front()) : 32'h0;
    reg_read(3'd1, d);
    chk(rq, d, e);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    chk("R1 tx_valid", {31'h0, tx_byte_valid}, 32'h0);
    reg_read(3'd2, v); chk("R1 status", v, 32'h3);
    reg_read(3'd0, v); chk("R1 intr", v, 32'h0);

    // R8 enables read back
    reg_write(3'd0, 32'hFFFF_FFFF);
    reg_read(3'd0, v); chk("R8 enable readback", v, 32'hF0);

    // R2 byte lane, R10 live status
    reg_write(3'd1, 32'hDEAD_A577);
    chk("R2 byte lane", {24'h0, tx_byte_data}, 32'hA5);
    reg_read(3'd2, v); chk("R10 status one byte", v, 32'h2);

    // R3 fill and overflow discard
    for (int i = 1; i < 8; i++) reg_write(3'd1, {16'h0, 8'(8'h10 + i), 8'h0});
    reg_read(3'd2, v); chk("R3 full status", v, 32'h0);
    reg_write(3'd1, 32'h0000_EE00);
    for (int i = 0; i < 8; i++) tx_drain_one("R3 order after full write");
    tx_drain_one("R3 empty after drain");

    // R7 rising edges of empty and room set requests
    reg_read(3'd0, v); chk("R7 req after drain", v, 32'hF3);
    chk("R8 irq with enabled req", {31'h0, irq_o}, 32'h1);
    reg_write(3'd0, 32'h0000_00F3);
    reg_read(3'd0, v); chk("R7 w1c clears", v, 32'hF0);
    chk("R8 irq low after clear", {31'h0, irq_o}, 32'h0);

    // R9 reserved offsets
    reg_write(3'd3, 32'hFFFF_FFFF);
    reg_write(3'd7, 32'hFFFF_FFFF);
    for (int a = 3; a < 8; a++) begin
      reg_read(3'(a), v); chk("R9 reserved read", v, 32'h0);
    end
    reg_read(3'd0, v); chk("R9 intr untouched", v, 32'hF0);
    reg_read(3'd2, v); chk("R9 status untouched", v, 32'h3);

    // R4 inbound order and lane
    rx_push(8'h5A); rx_push(8'hC3); rx_push(8'h01);
    reg_read(3'd2, v); chk("R4 status avail", v, 32'h7);
    reg_read(3'd0, v); chk("R7 rx avail req", v, 32'hF4);
    for (int i = 0; i < 3; i++) read_data_chk("R4 inbound byte");
    // R5 empty read
    read_data_chk("R5 empty read zero");
    rx_push(8'h99);
    read_data_chk("R5 next byte after empty read");

    // R6 overflow, enables off
    reg_write(3'd0, 32'h0000_000F);
    chk("R8 irq without enables", {31'h0, irq_o}, 32'h0);
    for (int i = 0; i < 9; i++) rx_push(8'(8'h40 + i));
    chk("R6 ready low when full", {31'h0, rx_byte_ready}, 32'h0);
    reg_read(3'd2, v); chk("R6 lost status", v, 32'hF);
    for (int i = 0; i < 8; i++) read_data_chk("R6 survivor byte");
    read_data_chk("R6 dropped byte absent");
    reg_read(3'd2, v); chk("R6 lost sticky", v, 32'hB);
    reg_write(3'd0, 32'h0000_0080);
    chk("R8 irq from lost req", {31'h0, irq_o}, 32'h1);
    reg_write(3'd2, 32'h0000_0008);
    reg_read(3'd2, v); chk("R6 status cleared", v, 32'h3);
    reg_read(3'd0, v); chk("R6 req independent", v[3:0], 32'hC);
    reg_write(3'd0, 32'h0000_000F);
    reg_read(3'd0, v); chk("R6 req cleared", v, 32'h0);

    // R10 writes to live bits ignored
    rx_push(8'h77);
    reg_write(3'd2, 32'hFFFF_FFF7);
    reg_read(3'd2, v); chk("R10 live bits kept", v, 32'h7);
    read_data_chk("R10 byte intact");

    // random mix against model
    void'($urandom(32'h1234_5678));
    for (int n = 0; n < 600; n++) begin
      case ($urandom_range(0, 5))
        0: rx_push(8'($urandom));
        1: reg_write(3'd1, $urandom);
        2: read_data_chk("R4 random read");
        3: tx_drain_one("R2 random drain");
        4: begin reg_read(3'd2, v); chk("R3 random status", v, exp_status()); end
        default: reg_write(3'd2, {28'h0, 4'($urandom)});
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule